// File: doc/BRIEF.md
# Reset Cause Collector with Low-Power Wakeup Tracking

This block gathers every source that may restart the system and turns them into one registered system reset request. The sources are a loss-of-clock indication from an external reference monitor, a low-supply level from a voltage comparator, the block's own power-on reset, the external reset pin, and a set of enabled wakeup sources (external pins plus internal peripherals). The monitor's frequency measurement and the analog comparison happen elsewhere. Both arrive here as digital inputs.

A five-bit status word records why the most recent reset flow happened. The word is rewritten when a new flow starts and extended while a flow is running. How a wakeup is treated depends on the current power mode. In the deep retention mode, any enabled wakeup source restarts the system. In the shallow retention mode, only the reset pin does; other enabled sources produce a one-cycle resume pulse instead.

A per-source wakeup flag register remembers which sources fired while the system was in a low-power mode. The system reset leaves these flags alone. They are cleared only by a write-one-to-clear software write, or by the next entry into a low-power mode.

Top module: `reset_cause_unit`

## Requirements
- R1: While `rst_i` (power-on reset) is sampled high, and on the cycle after it, `sys_rst_o` is 1, `wake_flags_o` is all zero, and `cause_o` is 5'b00011 (bit0 power-on, bit1 low-voltage). Status bit positions: bit0 power-on, bit1 low-voltage, bit2 clock loss, bit3 reset pin, bit4 low-power wakeup.
- R2: A cycle with `clkmon_en_i` and `clk_lost_i` both high makes `sys_rst_o` 1 and sets status bit2 on the next cycle. With `clkmon_en_i` low, `clk_lost_i` has no effect on `sys_rst_o`.
- R3: While `lvd_rst_en_i` and `lvd_low_i` are both high, `sys_rst_o` is held at 1 and status bit1 is set. With `lvd_rst_en_i` low, `lvd_low_i` is ignored.
- R4: `sys_rst_o` falls exactly 8 cycles (parameter STRETCH) after the last cycle in which any reset cause was sampled. This includes the power-on reset.
- R5: A cause seen while `sys_rst_o` is 0 starts a new flow whose status holds only that cycle's causes, so earlier bits are dropped. Causes seen during a running flow are ORed in. Causes that arrive together all set their bits.
- R6: `pmode_i` encodes 00 run, 01 shallow retention, 10 deep retention, 11 treated as run. In deep retention, any wakeup source with its `wake_en_i` bit set starts a reset flow and sets status bit4. Disabled sources are ignored.
- R7: In shallow retention, an enabled wakeup source (with no reset cause present) leaves `sys_rst_o` at 0 and pulses `wake_resume_o` for one cycle on the next cycle. The reset pin in shallow retention starts a flow with status bits 3 and 4 set.
- R8: The reset pin in run mode starts a flow with status bit3 set and bit4 clear.
- R9: `wake_flags_o[i]` sets on the cycle after source i is seen, enabled, in either low-power mode. Disabled sources and run mode set nothing. Flags are kept through system reset flows and mode changes back to run.
- R10: A cycle with `sw_wr_i` high clears every flag whose `sw_wdata_i` bit is 1 and keeps the others. A new wakeup on the same flag in the same cycle wins over the clear.
- R11: The first cycle in which `pmode_i` is a low-power mode after a run-mode cycle clears all flags, except those set by wakeups in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high power-on reset |
| clkmon_en_i | input | 1 | Clock monitor enable |
| clk_lost_i | input | 1 | Loss-of-reference pulse from the clock monitor |
| lvd_rst_en_i | input | 1 | Enables reset on low supply |
| lvd_low_i | input | 1 | Supply below threshold (level) |
| pin_rst_i | input | 1 | External reset pin, synchronised, active high |
| pmode_i | input | 2 | Power mode: 00 run, 01 shallow, 10 deep |
| wake_src_i | input | N_PIN+N_PERIPH | Wakeup events, pins in the low bits, peripherals above |
| wake_en_i | input | N_PIN+N_PERIPH | Per-source wakeup enable |
| sw_wr_i | input | 1 | Software write strobe for the flag register |
| sw_wdata_i | input | N_PIN+N_PERIPH | Write-one-to-clear mask |
| sys_rst_o | output | 1 | Registered system reset request |
| cause_o | output | 5 | Reset cause status of the latest flow |
| wake_flags_o | output | N_PIN+N_PERIPH | Sticky per-source wakeup flags |
| wake_resume_o | output | 1 | One-cycle resume pulse from shallow retention |

## Verification
The bound assertions check the following on every cycle: clock-loss and low-voltage triggering, the mode-dependent wakeup response, the run-mode pin status, the exact release distance after the last cause, the dropping of the power-on bit at a new flow, flag stickiness outside clears and entries, and software clearing outside low-power modes. The bench scenarios are needed for the rest: ORing of late causes into a running flow, a set winning over a clear in the same cycle, the entry clear after a visit to run mode, and flags surviving a full reset flow. A behavioural model in the bench is also compared against every output on every cycle.

// File: rtl/rcu_pkg.sv
package rcu_pkg;

  typedef enum logic [1:0] {
    PM_RUN     = 2'b00,
    PM_SHALLOW = 2'b01,
    PM_DEEP    = 2'b10,
    PM_RSVD    = 2'b11
  } pmode_e;

  // Bit order of the packed struct fixes the status positions:
  // bit4 wake, bit3 pin, bit2 clock loss, bit1 low voltage, bit0 power-on.
  typedef struct packed {
    logic wake;
    logic pin;
    logic loc;
    logic lvd;
    logic por;
  } cause_t;

  localparam int CAUSE_W = $bits(cause_t);

  localparam cause_t CAUSE_AFTER_POR = '{wake: 1'b0, pin: 1'b0, loc: 1'b0,
                                         lvd: 1'b1, por: 1'b1};

  function automatic logic is_low_power(input pmode_e m);
    return (m == PM_SHALLOW) || (m == PM_DEEP);
  endfunction

endpackage

// File: rtl/rcu_cause_decode.sv
module rcu_cause_decode
  import rcu_pkg::*;
#(
  parameter int N_SRC = 23
) (
  input  logic             clkmon_en_i,
  input  logic             clk_lost_i,
  input  logic             lvd_rst_en_i,
  input  logic             lvd_low_i,
  input  logic             pin_rst_i,
  input  logic [1:0]       pmode_i,
  input  logic [N_SRC-1:0] wake_src_i,
  input  logic [N_SRC-1:0] wake_en_i,
  output cause_t           now_cause_o,
  output logic             any_cause_o,
  output logic [N_SRC-1:0] flag_set_o,
  output logic             resume_req_o
);

  pmode_e           mode;
  logic             deep;
  logic             shallow;
  logic             low_pwr;
  logic [N_SRC-1:0] hit;
  logic             any_hit;
  logic             deep_wake;

  assign mode    = pmode_e'(pmode_i);
  assign deep    = (mode == PM_DEEP);
  assign shallow = (mode == PM_SHALLOW);
  assign low_pwr = is_low_power(mode);

  // Per-source qualification: an event counts only when its enable is set
  // and the system sits in one of the retention modes.
  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    assign hit[i]        = wake_src_i[i] & wake_en_i[i];
    assign flag_set_o[i] = hit[i] & low_pwr;
  end

  assign any_hit   = |hit;
  assign deep_wake = deep & any_hit;

  always_comb begin
    now_cause_o      = '0;
    now_cause_o.loc  = clkmon_en_i & clk_lost_i;
    now_cause_o.lvd  = lvd_rst_en_i & lvd_low_i;
    now_cause_o.pin  = pin_rst_i;
    now_cause_o.wake = deep_wake | (low_pwr & pin_rst_i);
  end

  assign any_cause_o  = now_cause_o.loc | now_cause_o.lvd |
                        now_cause_o.pin | deep_wake;
  assign resume_req_o = shallow & any_hit & ~any_cause_o;

endmodule

// File: rtl/rcu_rst_stretch.sv
module rcu_rst_stretch #(
  parameter int STRETCH = 8
) (
  input  logic clk,
  input  logic rst_i,
  input  logic any_cause_i,
  output logic sys_rst_o
);

  localparam int CNT_W = $clog2(STRETCH + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(STRETCH - 1);

  logic [CNT_W-1:0] quiet_cnt;

  // The counter measures cause-free cycles inside a flow; any cause,
  // including power-on, restarts the measurement.
  always_ff @(posedge clk) begin
    if (rst_i) begin
      sys_rst_o <= 1'b1;
      quiet_cnt <= '0;
    end else if (any_cause_i) begin
      sys_rst_o <= 1'b1;
      quiet_cnt <= '0;
    end else if (sys_rst_o) begin
      if (quiet_cnt == LAST) begin
        sys_rst_o <= 1'b0;
        quiet_cnt <= '0;
      end else begin
        quiet_cnt <= quiet_cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/rcu_cause_reg.sv
module rcu_cause_reg
  import rcu_pkg::*;
(
  input  logic   clk,
  input  logic   rst_i,
  input  cause_t now_cause_i,
  input  logic   any_cause_i,
  input  logic   in_flow_i,
  output cause_t cause_o
);

  always_ff @(posedge clk) begin
    if (rst_i) begin
      cause_o <= CAUSE_AFTER_POR;
    end else if (any_cause_i) begin
      if (in_flow_i) begin
        cause_o <= cause_o | now_cause_i;
      end else begin
        cause_o <= now_cause_i;
      end
    end
  end

endmodule

// File: rtl/rcu_wake_flags.sv
module rcu_wake_flags
  import rcu_pkg::*;
#(
  parameter int N_SRC = 23
) (
  input  logic             clk,
  input  logic             rst_i,
  input  logic [1:0]       pmode_i,
  input  logic [N_SRC-1:0] flag_set_i,
  input  logic             resume_req_i,
  input  logic             sw_wr_i,
  input  logic [N_SRC-1:0] sw_wdata_i,
  output logic [N_SRC-1:0] flags_o,
  output logic             resume_o
);

  logic lp_prev;
  logic lp_now;
  logic entry;

  assign lp_now = is_low_power(pmode_e'(pmode_i));
  assign entry  = lp_now & ~lp_prev;

  always_ff @(posedge clk) begin
    if (rst_i) begin
      lp_prev  <= 1'b0;
      resume_o <= 1'b0;
    end else begin
      lp_prev  <= lp_now;
      resume_o <= resume_req_i;
    end
  end

  // One storage bit per source; a new event always wins over a clear.
  for (genvar i = 0; i < N_SRC; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst_i) begin
        flags_o[i] <= 1'b0;
      end else if (entry || (sw_wr_i && sw_wdata_i[i])) begin
        flags_o[i] <= flag_set_i[i];
      end else if (flag_set_i[i]) begin
        flags_o[i] <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/reset_cause_unit.sv
module reset_cause_unit
  import rcu_pkg::*;
#(
  parameter int N_PIN    = 16,
  parameter int N_PERIPH = 7,
  parameter int STRETCH  = 8,
  localparam int N_SRC   = N_PIN + N_PERIPH
) (
  input  logic             clk,
  input  logic             rst_i,
  input  logic             clkmon_en_i,
  input  logic             clk_lost_i,
  input  logic             lvd_rst_en_i,
  input  logic             lvd_low_i,
  input  logic             pin_rst_i,
  input  logic [1:0]       pmode_i,
  input  logic [N_SRC-1:0] wake_src_i,
  input  logic [N_SRC-1:0] wake_en_i,
  input  logic             sw_wr_i,
  input  logic [N_SRC-1:0] sw_wdata_i,
  output logic             sys_rst_o,
  output logic [4:0]       cause_o,
  output logic [N_SRC-1:0] wake_flags_o,
  output logic             wake_resume_o
);

  cause_t           now_cause;
  cause_t           cause_q;
  logic             any_cause;
  logic [N_SRC-1:0] flag_set;
  logic             resume_req;
  logic             rst_q;

  rcu_cause_decode #(.N_SRC(N_SRC)) u_decode (
    .clkmon_en_i  (clkmon_en_i),
    .clk_lost_i   (clk_lost_i),
    .lvd_rst_en_i (lvd_rst_en_i),
    .lvd_low_i    (lvd_low_i),
    .pin_rst_i    (pin_rst_i),
    .pmode_i      (pmode_i),
    .wake_src_i   (wake_src_i),
    .wake_en_i    (wake_en_i),
    .now_cause_o  (now_cause),
    .any_cause_o  (any_cause),
    .flag_set_o   (flag_set),
    .resume_req_o (resume_req)
  );

  rcu_rst_stretch #(.STRETCH(STRETCH)) u_stretch (
    .clk         (clk),
    .rst_i       (rst_i),
    .any_cause_i (any_cause),
    .sys_rst_o   (rst_q)
  );

  rcu_cause_reg u_cause (
    .clk         (clk),
    .rst_i       (rst_i),
    .now_cause_i (now_cause),
    .any_cause_i (any_cause),
    .in_flow_i   (rst_q),
    .cause_o     (cause_q)
  );

  rcu_wake_flags #(.N_SRC(N_SRC)) u_flags (
    .clk          (clk),
    .rst_i        (rst_i),
    .pmode_i      (pmode_i),
    .flag_set_i   (flag_set),
    .resume_req_i (resume_req),
    .sw_wr_i      (sw_wr_i),
    .sw_wdata_i   (sw_wdata_i),
    .flags_o      (wake_flags_o),
    .resume_o     (wake_resume_o)
  );

  assign sys_rst_o = rst_q;
  assign cause_o   = cause_q;

endmodule

// File: rtl/rcu_checker.sv
module rcu_checker #(
  parameter int N_PIN    = 16,
  parameter int N_PERIPH = 7,
  parameter int STRETCH  = 8,
  localparam int N_SRC   = N_PIN + N_PERIPH
) (
  input logic             clk,
  input logic             rst_i,
  input logic             clkmon_en_i,
  input logic             clk_lost_i,
  input logic             lvd_rst_en_i,
  input logic             lvd_low_i,
  input logic             pin_rst_i,
  input logic [1:0]       pmode_i,
  input logic [N_SRC-1:0] wake_src_i,
  input logic [N_SRC-1:0] wake_en_i,
  input logic             sw_wr_i,
  input logic [N_SRC-1:0] sw_wdata_i,
  input logic             sys_rst_o,
  input logic [4:0]       cause_o,
  input logic [N_SRC-1:0] wake_flags_o,
  input logic             wake_resume_o
);

  logic in_lp;
  logic enabled_hit;
  logic any_in;
  logic lp_seen;
  logic entry;
  logic por_seen;
  int   quiet;

  assign in_lp       = (pmode_i == 2'b01) || (pmode_i == 2'b10);
  assign enabled_hit = |(wake_src_i & wake_en_i);
  assign any_in      = (clkmon_en_i && clk_lost_i) || (lvd_rst_en_i && lvd_low_i) ||
                       pin_rst_i || ((pmode_i == 2'b10) && enabled_hit);
  assign entry       = in_lp && !lp_seen;

  always_ff @(posedge clk) begin
    if (rst_i) begin
      quiet   <= 0;
      lp_seen <= 1'b0;
    end else begin
      quiet   <= any_in ? 0 : ((quiet < 1000) ? quiet + 1 : quiet);
      lp_seen <= in_lp;
    end
    por_seen <= rst_i;
  end

  // R1: state right after a power-on reset cycle
  always_ff @(posedge clk) begin
    if (por_seen) begin
      p_por_state_r1: assert (sys_rst_o && cause_o == 5'b00011 && wake_flags_o == '0)
        else $error("R1 post-reset state wrong");
    end
  end

  p_loc_trigger_r2: assert property (@(posedge clk) disable iff (rst_i)
    (clkmon_en_i && clk_lost_i) |=> (sys_rst_o && cause_o[2]));

  p_lvd_hold_r3: assert property (@(posedge clk) disable iff (rst_i)
    (lvd_rst_en_i && lvd_low_i) |=> (sys_rst_o && cause_o[1]));

  p_release_gap_r4: assert property (@(posedge clk) disable iff (rst_i)
    $fell(sys_rst_o) |-> (quiet == STRETCH));

  p_new_flow_drops_por_r5: assert property (@(posedge clk) disable iff (rst_i)
    (!sys_rst_o && any_in) |=> !cause_o[0]);

  p_deep_wake_r6: assert property (@(posedge clk) disable iff (rst_i)
    ((pmode_i == 2'b10) && enabled_hit) |=> (sys_rst_o && cause_o[4]));

  p_shallow_resume_r7: assert property (@(posedge clk) disable iff (rst_i)
    ((pmode_i == 2'b01) && enabled_hit && !any_in && !sys_rst_o)
      |=> (wake_resume_o && !sys_rst_o));

  p_run_pin_r8: assert property (@(posedge clk) disable iff (rst_i)
    (pin_rst_i && !in_lp && !sys_rst_o) |=> (cause_o[3] && !cause_o[4]));

  p_flag_sticky_r9: assert property (@(posedge clk) disable iff (rst_i)
    (!sw_wr_i && !entry)
      |=> ((wake_flags_o & $past(wake_flags_o)) == $past(wake_flags_o)));

  p_sw_clear_r10: assert property (@(posedge clk) disable iff (rst_i)
    (sw_wr_i && !in_lp) |=> ((wake_flags_o & $past(sw_wdata_i)) == '0));

endmodule

bind reset_cause_unit rcu_checker #(
  .N_PIN    (N_PIN),
  .N_PERIPH (N_PERIPH),
  .STRETCH  (STRETCH)
) u_rcu_checker (.*);

// File: tb/reset_cause_unit_bench.sv
module reset_cause_unit_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NS = 23;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          mon_en = 0, lost = 0, lvd_en = 0, lvd_low = 0, pin = 0, sw_wr = 0;
  logic [1:0]    pmode = 2'b00;
  logic [NS-1:0] src = '0, en = '0, wd = '0;
  logic          sys_rst, resume;
  logic [4:0]    cause;
  logic [NS-1:0] flags;

  int tests = 0, fails = 0;
  bit started = 0, done = 0;
  string cur_req = "R1";

  // behavioural reference state
  bit          m_rst, m_resume, m_prev_lp;
  int          m_hold;
  logic [4:0]  m_cause;
  logic [NS-1:0] m_flags;

  always #(CLK_PERIOD/2) clk = ~clk;

  reset_cause_unit u_reset_cause_unit (
    .clk(clk), .rst_i(rst), .clkmon_en_i(mon_en), .clk_lost_i(lost),
    .lvd_rst_en_i(lvd_en), .lvd_low_i(lvd_low), .pin_rst_i(pin),
    .pmode_i(pmode), .wake_src_i(src), .wake_en_i(en),
    .sw_wr_i(sw_wr), .sw_wdata_i(wd),
    .sys_rst_o(sys_rst), .cause_o(cause), .wake_flags_o(flags),
    .wake_resume_o(resume)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    bit lp, deep, anyc;
    logic [NS-1:0] hits, setv;
    logic [4:0] nc;
    if (rst) begin
      m_rst = 1; m_hold = 8; m_cause = 5'b00011; m_flags = '0;
      m_prev_lp = 0; m_resume = 0;
    end else begin
      hits = src & en;
      lp   = (pmode == 2'b01) || (pmode == 2'b10);
      deep = (pmode == 2'b10);
      nc   = 5'b0;
      if (mon_en && lost) nc[2] = 1;
      if (lvd_en && lvd_low) nc[1] = 1;
      if (pin) nc[3] = 1;
      if ((deep && hits != 0) || (lp && pin)) nc[4] = 1;
      anyc = (nc[3:1] != 0) || (deep && hits != 0);
      m_resume = (pmode == 2'b01) && (hits != 0) && !anyc;
      if (anyc) begin
        m_cause = m_rst ? (m_cause | nc) : nc;
        m_rst = 1; m_hold = 8;
      end else if (m_hold > 0) begin
        m_hold--;
        if (m_hold == 0) m_rst = 0;
      end
      setv = lp ? hits : '0;
      if (lp && !m_prev_lp) m_flags = setv;
      else if (sw_wr) m_flags = (m_flags & ~wd) | setv;
      else m_flags = m_flags | setv;
      m_prev_lp = lp;
    end
  end

  always @(negedge clk) begin
    if (started && !done) begin
      chk(sys_rst == m_rst, {cur_req, " model sys_rst"}, 32'(sys_rst), 32'(m_rst));
      chk(cause == m_cause, {cur_req, " model cause"}, 32'(cause), 32'(m_cause));
      chk(flags == m_flags, {cur_req, " model flags"}, 32'(flags), 32'(m_flags));
      chk(resume == m_resume, {cur_req, " model resume"}, 32'(resume), 32'(m_resume));
    end
  end

  task automatic wait_release(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (sys_rst && n < 40);
  endtask

  task automatic pulse_cycle();
    @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    started = 1;
    chk(sys_rst == 1 && cause == 5'b00011 && flags == '0, "R1 reset state",
        {cause, 7'b0, flags[19:0]}, {5'b00011, 27'b0});
    rst = 0;
    wait_release(n);
    chk(n == 8, "R4 release after power-on", n, 8);

    // R2: clock loss
    cur_req = "R2";
    lost = 1; pulse_cycle(); lost = 0;
    chk(sys_rst == 0, "R2 loss ignored when monitor off", 32'(sys_rst), 0);
    mon_en = 1; lost = 1; pulse_cycle(); lost = 0;
    chk(sys_rst == 1 && cause == 5'b00100, "R2 loss reset, R5 por dropped", 32'(cause), 5'b00100);
    wait_release(n);
    chk(n == 8, "R4 release after clock loss", n, 8);

    // R3: low voltage
    cur_req = "R3";
    lvd_low = 1; repeat (3) pulse_cycle();
    chk(sys_rst == 0, "R3 low voltage ignored when disabled", 32'(sys_rst), 0);
    lvd_en = 1; repeat (12) pulse_cycle();
    chk(sys_rst == 1 && cause == 5'b00010, "R3 held while low", 32'(cause), 5'b00010);
    lvd_low = 0;
    wait_release(n);
    chk(n == 8, "R4 release after supply recovers", n, 8);

    // R5: simultaneous and late causes
    cur_req = "R5";
    lost = 1; pin = 1; pulse_cycle(); lost = 0; pin = 0;
    chk(cause == 5'b01100, "R5 simultaneous causes", 32'(cause), 5'b01100);
    pulse_cycle();
    lvd_low = 1; pulse_cycle(); lvd_low = 0;
    chk(cause == 5'b01110, "R5 cause added during flow", 32'(cause), 5'b01110);
    wait_release(n);

    // R8: pin in run mode
    cur_req = "R8";
    pin = 1; pulse_cycle(); pin = 0;
    chk(sys_rst == 1 && cause == 5'b01000, "R8 run-mode pin", 32'(cause), 5'b01000);
    wait_release(n);

    // R9: run-mode wake source sets nothing
    cur_req = "R9";
    en = 23'h100008;
    src = 23'h000008; pulse_cycle(); src = '0;
    chk(flags == '0 && sys_rst == 0, "R9 run mode ignores wake", 32'(flags), 0);

    // R7: shallow retention
    cur_req = "R7";
    pmode = 2'b01; pulse_cycle();
    src = 23'h000008; pulse_cycle(); src = '0;
    chk(sys_rst == 0 && resume == 1, "R7 shallow wake resumes", 32'(resume), 1);
    chk(flags == 23'h000008, "R9 flag set in shallow", 32'(flags), 32'h8);
    pulse_cycle();
    chk(resume == 0, "R7 resume one cycle", 32'(resume), 0);
    src = 23'h000020; pulse_cycle(); src = '0;
    chk(flags == 23'h000008, "R9 disabled source ignored", 32'(flags), 32'h8);
    pin = 1; pulse_cycle(); pin = 0;
    chk(sys_rst == 1 && cause == 5'b11000, "R7 pin exit from shallow", 32'(cause), 5'b11000);
    wait_release(n);
    chk(flags == 23'h000008, "R9 flags survive reset", 32'(flags), 32'h8);

    // R10: software clear
    cur_req = "R10";
    sw_wr = 1; wd = 23'h000008; src = 23'h100000; pulse_cycle();
    chk(flags == 23'h100000, "R10 clear one, set other", 32'(flags), 32'h100000);
    wd = 23'h100000; pulse_cycle();
    sw_wr = 0; wd = '0; src = '0;
    chk(flags == 23'h100000, "R10 set wins over clear", 32'(flags), 32'h100000);

    // R11: entry clears
    cur_req = "R11";
    pmode = 2'b00; repeat (2) pulse_cycle();
    chk(flags == 23'h100000, "R9 flags kept in run", 32'(flags), 32'h100000);
    pmode = 2'b10; pulse_cycle();
    chk(flags == '0, "R11 entry clears flags", 32'(flags), 0);

    // R6: deep retention
    cur_req = "R6";
    src = 23'h000020; pulse_cycle(); src = '0;
    chk(sys_rst == 0, "R6 disabled source ignored in deep", 32'(sys_rst), 0);
    src = 23'h100000; pulse_cycle(); src = '0;
    chk(sys_rst == 1 && cause == 5'b10000, "R6 deep wake reset", 32'(cause), 5'b10000);
    chk(flags == 23'h100000, "R9 deep flag set", 32'(flags), 32'h100000);
    pmode = 2'b00;
    wait_release(n);
    chk(n == 8, "R4 release after deep wake", n, 8);
    repeat (3) pulse_cycle();

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule